// File: doc/BRIEF.md
# Fractional Complex Multiply Unit

This block is an execution-stage arithmetic unit for signed Q15 fractional data. Each 32-bit operand carries two 16-bit two's-complement fractions in the range -1 (inclusive) to +1 (exclusive): the upper half at bits 31:16 and the lower half at bits 15:0. A 4-bit one-hot operation code selects one of three operations: a complex multiply (upper half real, lower half imaginary), two independent lane-wise fractional multiplies, or a single fractional multiply on the lower halves. A fourth code means no operation.

Operands and opcode are captured in input registers. Four 16x16 signed multipliers form the upper*upper, upper*lower, lower*upper and lower*lower products. A subtractor and an adder combine these for the complex case. A three-way multiplexer, steered directly by opcode bits, picks the result. The result and an overflow flag are registered at the output. Results are brought back to 16-bit precision by dropping low-order bits. The overflow flag reports a final value that lies outside the Q15 range. On a no-operation, and on any opcode that is not one-hot, the output registers keep their contents.

Top module: `cfm_unit`

## Requirements
- R1: A synchronous active-high reset clears the result to 0, the overflow flag to 0 and the captured opcode to 4'b0000.
- R2: A value applied at the ports is captured on one rising edge. Its result and flag appear on the outputs after the next rising edge, which is two edges in total.
- R3: Opcode 4'b1000 (bit 3) performs a complex multiply. z[31:16] is bits 30:15 of the 33-bit difference upper*upper - lower*lower. z[15:0] is bits 30:15 of the 33-bit sum upper*lower + lower*upper.
- R4: For the complex multiply, the flag is set when bits 32:30 of either the 33-bit difference or the 33-bit sum are not all equal. An out-of-range partial product alone does not set it.
- R5: Opcode 4'b0100 (bit 2) performs two parallel multiplies. z[31:16] is bits 30:15 of upper*upper and z[15:0] is bits 30:15 of lower*lower.
- R6: For the parallel multiply, the flag is set when bits 31 and 30 differ in either 32-bit product. This happens only for -1 times -1, whose truncated result reads 16'h8000.
- R7: Opcode 4'b0010 (bit 1) performs a single multiply. z[15:0] is bits 30:15 of lower*lower, z[31:16] is 0, and the flag reflects only the lower*lower product.
- R8: Truncation drops the 15 low-order bits with no rounding, so a negative result rounds toward minus infinity.
- R9: Opcode 4'b0001 (bit 0) writes neither the result nor the flag, and both keep their earlier values.
- R10: Any opcode that is not one-hot, including 4'b0000, behaves as a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a_i | input | 32 | First operand: upper Q15 half at 31:16, lower half at 15:0 |
| opnd_b_i | input | 32 | Second operand, same packing |
| op_i | input | 4 | One-hot operation code |
| z_o | output | 32 | Registered result |
| ovf_o | output | 1 | Registered overflow flag |

## Verification
The hardest case to reach is a complex multiply in which a partial product is itself out of range (-1 times -1) while the final difference lands back inside Q15. Only a specific operand pairing produces it. The stimulus uses upper halves of -1 and lower halves of 0.5, so the +1 partial product is pulled down to 0.75 by the subtraction, and the bench requires the flag to stay low. Hold behaviour is checked by following a flagged result with no-operation and malformed opcodes carrying fresh operands, then confirming that the outputs have not moved.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  // opcode bit positions (one-hot)
  localparam int OP_W    = 4;
  localparam int OPB_NOP = 0;
  localparam int OPB_SGL = 1;
  localparam int OPB_PAR = 2;
  localparam int OPB_CX  = 3;

  // partial product indices: index/2 picks operand A half, index%2 picks B half (0 = upper)
  localparam int NPP   = 4;
  localparam int PP_HH = 0;
  localparam int PP_HL = 1;
  localparam int PP_LH = 2;
  localparam int PP_LL = 3;

  // result multiplexer inputs
  localparam int NMUX    = 3;
  localparam int MUX_PAR = 0;
  localparam int MUX_SGL = 1;
  localparam int MUX_CX  = 2;
endpackage

// File: rtl/cfm_in_reg.sv
module cfm_in_reg
  import cfm_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2*HW-1:0] a_i,
  input  logic [2*HW-1:0] b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [2*HW-1:0] a_q,
  output logic [2*HW-1:0] b_q,
  output logic [OP_W-1:0] op_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q  <= '0;
      b_q  <= '0;
      op_q <= '0;
    end else begin
      a_q  <= a_i;
      b_q  <= b_i;
      op_q <= op_i;
    end
  end
endmodule

// File: rtl/cfm_mul.sv
module cfm_mul #(
  parameter int HW = 16
) (
  input  logic signed [HW-1:0]   x_i,
  input  logic signed [HW-1:0]   y_i,
  output logic signed [2*HW-1:0] p_o
);
  assign p_o = x_i * y_i;
endmodule

// File: rtl/cfm_datapath.sv
module cfm_datapath
  import cfm_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic [2*HW-1:0] a_i,
  input  logic [2*HW-1:0] b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [2*HW-1:0] z_o,
  output logic            ovf_o,
  output logic            we_o
);
  localparam int PW  = 2 * HW;  // product width
  localparam int SW  = PW + 1;  // sum / difference width
  localparam int TOP = PW - 2;  // highest kept bit
  localparam int BOT = HW - 1;  // lowest kept bit

  logic signed [HW-1:0] a_h, a_l, b_h, b_l;
  logic signed [PW-1:0] prod [NPP];
  logic signed [SW-1:0] re_s, im_s;
  logic [PW-1:0]        res   [NMUX];
  logic [NMUX-1:0]      ovf_l;
  logic [NMUX-1:0]      sel;
  logic [2*BOT-1:0]     unused_sum_lsbs;

  assign a_h = a_i[PW-1:HW];
  assign a_l = a_i[HW-1:0];
  assign b_h = b_i[PW-1:HW];
  assign b_l = b_i[HW-1:0];

  generate
    for (genvar g = 0; g < NPP; g++) begin : g_mul
      cfm_mul #(.HW(HW)) u_mul (
        .x_i (((g / 2) == 0) ? a_h : a_l),
        .y_i (((g % 2) == 0) ? b_h : b_l),
        .p_o (prod[g])
      );
    end
  endgenerate

  assign re_s = {prod[PP_HH][PW-1], prod[PP_HH]} - {prod[PP_LL][PW-1], prod[PP_LL]};
  assign im_s = {prod[PP_HL][PW-1], prod[PP_HL]} + {prod[PP_LH][PW-1], prod[PP_LH]};
  assign unused_sum_lsbs = {re_s[BOT-1:0], im_s[BOT-1:0]};

  function automatic logic prod_out_of_range(input logic [PW-1:0] p);
    return p[PW-1] ^ p[PW-2];
  endfunction

  function automatic logic sum_out_of_range(input logic [SW-1:0] s);
    return !((s[SW-1:SW-3] == 3'b000) || (s[SW-1:SW-3] == 3'b111));
  endfunction

  always_comb begin
    res[MUX_PAR]   = {prod[PP_HH][TOP:BOT], prod[PP_LL][TOP:BOT]};
    ovf_l[MUX_PAR] = prod_out_of_range(prod[PP_HH]) | prod_out_of_range(prod[PP_LL]);
    res[MUX_SGL]   = {{HW{1'b0}}, prod[PP_LL][TOP:BOT]};
    ovf_l[MUX_SGL] = prod_out_of_range(prod[PP_LL]);
    res[MUX_CX]    = {re_s[TOP:BOT], im_s[TOP:BOT]};
    ovf_l[MUX_CX]  = sum_out_of_range(re_s) | sum_out_of_range(im_s);
  end

  // multiplexer select comes straight from opcode bits, no decoding
  assign sel[MUX_PAR] = op_i[OPB_PAR];
  assign sel[MUX_SGL] = op_i[OPB_SGL];
  assign sel[MUX_CX]  = op_i[OPB_CX];

  always_comb begin
    z_o   = '0;
    ovf_o = 1'b0;
    for (int k = 0; k < NMUX; k++) begin
      z_o   = z_o | (res[k] & {PW{sel[k]}});
      ovf_o = ovf_o | (ovf_l[k] & sel[k]);
    end
  end

  assign we_o = $onehot(op_i) && !op_i[OPB_NOP];
endmodule

// File: rtl/cfm_out_reg.sv
module cfm_out_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] z_d,
  input  logic         ovf_d,
  output logic [W-1:0] z_q,
  output logic         ovf_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      z_q   <= '0;
      ovf_q <= 1'b0;
    end else if (we) begin
      z_q   <= z_d;
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/cfm_unit.sv
module cfm_unit
  import cfm_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2*HW-1:0] opnd_a_i,
  input  logic [2*HW-1:0] opnd_b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [2*HW-1:0] z_o,
  output logic            ovf_o
);
  localparam int DW = 2 * HW;

  logic [DW-1:0]   a_q, b_q, z_d;
  logic [OP_W-1:0] op_q;
  logic            ovf_d, we;

  cfm_in_reg #(.HW(HW)) u_in (
    .clk  (clk),
    .rst  (rst),
    .a_i  (opnd_a_i),
    .b_i  (opnd_b_i),
    .op_i (op_i),
    .a_q  (a_q),
    .b_q  (b_q),
    .op_q (op_q)
  );

  cfm_datapath #(.HW(HW)) u_dp (
    .a_i   (a_q),
    .b_i   (b_q),
    .op_i  (op_q),
    .z_o   (z_d),
    .ovf_o (ovf_d),
    .we_o  (we)
  );

  cfm_out_reg #(.W(DW)) u_out (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .z_d   (z_d),
    .ovf_d (ovf_d),
    .z_q   (z_o),
    .ovf_q (ovf_o)
  );

  // R1: reset clears the outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (z_o == '0) && !ovf_o);

  // R9: a captured no-operation leaves the outputs alone
  a_r9_nop_hold: assert property (@(posedge clk) disable iff (rst)
    (op_q == 4'b0001) |=> $stable(z_o) && $stable(ovf_o));

  // R10: a malformed opcode leaves the outputs alone
  a_r10_bad_op_hold: assert property (@(posedge clk) disable iff (rst)
    !$onehot(op_q) |=> $stable(z_o) && $stable(ovf_o));

  // R7: the single multiply leaves the upper result half at zero
  a_r7_single_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (op_q == 4'b0010) |=> (z_o[DW-1:HW] == '0));

  // R6: -1 * -1 on the lower lane of a parallel multiply raises the flag
  a_r6_min_square_flag: assert property (@(posedge clk) disable iff (rst)
    ((op_q == 4'b0100) && (a_q[HW-1:0] == {1'b1, {(HW-1){1'b0}}})
      && (b_q[HW-1:0] == {1'b1, {(HW-1){1'b0}}})) |=> ovf_o);
endmodule

// File: tb/cfm_unit_test.sv
`timescale 1ns/1ps
module cfm_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [3:0]  op = 4'b0001;
  logic [31:0] z;
  logic        ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  cfm_unit uut (
    .clk      (clk),
    .rst      (rst),
    .opnd_a_i (opnd_a),
    .opnd_b_i (opnd_b),
    .op_i     (op),
    .z_o      (z),
    .ovf_o    (ovf)
  );

  // {op, a, b, expected z, expected flag}
  localparam int NV = 14;
  localparam logic [100:0] VEC [NV] = '{
    {4'b1000, 32'h40004000, 32'h40004000, 32'h00004000, 1'b0},  // R3 (0.5+0.5j)^2
    {4'b1000, 32'h80004000, 32'h80004000, 32'h60008000, 1'b0},  // R4 partial +1 ignored
    {4'b1000, 32'h80008000, 32'h80008000, 32'h00000000, 1'b1},  // R4 imaginary out of range
    {4'b1000, 32'h80000000, 32'h80000000, 32'h80000000, 1'b1},  // R4 real out of range
    {4'b0100, 32'h40002000, 32'h4000C000, 32'h2000F000, 1'b0},  // R5 two lanes
    {4'b0100, 32'h40008000, 32'h40008000, 32'h20008000, 1'b1},  // R6 lower lane -1*-1
    {4'b0100, 32'h80001000, 32'h80001000, 32'h80000200, 1'b1},  // R6 upper lane -1*-1
    {4'b0010, 32'h7FFF4000, 32'h7FFF4000, 32'h00002000, 1'b0},  // R7 upper halves ignored
    {4'b0010, 32'h80002000, 32'h80004000, 32'h00001000, 1'b0},  // R7 upper -1*-1 not flagged
    {4'b0010, 32'h00008000, 32'h00008000, 32'h00008000, 1'b1},  // R7 lower -1*-1 flagged
    {4'b0010, 32'h0000FFFF, 32'h00004000, 32'h0000FFFF, 1'b0},  // R8 negative floors
    {4'b0010, 32'h00000001, 32'h00004000, 32'h00000000, 1'b0},  // R8 tiny positive drops to 0
    {4'b1000, 32'hFFFF0000, 32'h40000000, 32'hFFFF0000, 1'b0},  // R8 complex real floors
    {4'b0100, 32'h7FFF7FFF, 32'h7FFF7FFF, 32'h7FFE7FFE, 1'b0}   // R5 near +1 squared
  };
  localparam int VREQ [NV] = '{3, 4, 4, 4, 5, 6, 6, 7, 7, 7, 8, 8, 8, 5};

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op = o;
    opnd_a = a;
    opnd_b = b;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] held_z;
    logic        held_f;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", {z, ovf}, 33'h0);

    // table walk: drive, then two edges to the outputs
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][100:97], VEC[i][96:65], VEC[i][64:33]);
      @(negedge clk);
      @(negedge clk);
      chk($sformatf("R%0d vec%0d", VREQ[i], i), {z, ovf}, VEC[i][32:0]);
    end

    // R2: latency of two edges
    apply(4'b0010, 32'h00004000, 32'h00004000);  // 0.25 -> 16'h2000
    @(negedge clk);
    chk("R2 after one edge", {z, ovf}, {32'h7FFE7FFE, 1'b0});
    @(negedge clk);
    chk("R2 after two edges", {z, ovf}, {32'h00002000, 1'b0});

    // set a flagged result, then try to disturb it
    apply(4'b0100, 32'h80008000, 32'h80008000);
    @(negedge clk);
    @(negedge clk);
    held_z = z;
    held_f = ovf;
    chk("R6 both lanes", {held_z, held_f}, {32'h80008000, 1'b1});

    // R9: no-operation with new operands
    apply(4'b0001, 32'h40004000, 32'h40004000);
    @(negedge clk);
    @(negedge clk);
    chk("R9 nop hold", {z, ovf}, {held_z, held_f});

    // R10: malformed opcodes
    apply(4'b0000, 32'h12345678, 32'h7FFF7FFF);
    @(negedge clk);
    @(negedge clk);
    chk("R10 op 0000 hold", {z, ovf}, {held_z, held_f});
    apply(4'b0110, 32'h40004000, 32'h40004000);
    @(negedge clk);
    @(negedge clk);
    chk("R10 op 0110 hold", {z, ovf}, {held_z, held_f});
    apply(4'b1111, 32'h40004000, 32'h40004000);
    @(negedge clk);
    @(negedge clk);
    chk("R10 op 1111 hold", {z, ovf}, {held_z, held_f});
    apply(4'b1001, 32'h40004000, 32'h40004000);
    @(negedge clk);
    @(negedge clk);
    chk("R10 op 1001 hold", {z, ovf}, {held_z, held_f});

    // R1: reset mid-run clears a flagged result
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    op = 4'b0001;
    chk("R1 mid-run reset", {z, ovf}, 33'h0);
    @(negedge clk);
    @(negedge clk);
    chk("R1 captured op cleared", {z, ovf}, 33'h0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule